// File: doc/BRIEF.md
# Carry-Split Pipelined Accumulator

This block keeps a running sum of a W-bit input stream without ever needing a full-width carry chain inside one clock period. The sum is divided into NSTAGES slices of equal width. Each slice has its own small accumulator. The carry leaving a slice is captured in a register and consumed by the next slice one step later. To line up with that delayed carry, slice k of every input word is first held back by k steps. After its accumulator, each slice then passes through enough delay registers that all slices of one result arrive at the output together. Every path through the block holds exactly PIPELINE registers. PIPELINE may be larger than NSTAGES, and the surplus appears as extra output-side delay.

A parameter selects how the pipeline advances. In the every-clock mode all registers move on every clock. A cycle with `en` low then feeds a zero word into the pipeline, while registered carries already in flight keep travelling. In the enable-gated mode every register, including the slice accumulators and carry registers, moves only on clocks where `en` is high. A one-bit flag travels alongside the data and marks which output words contain a real input sample. The sum wraps modulo 2^W, and reset returns the sum to zero.

Top module: `carry_split_acc`

## Requirements
- R1: A clock edge with `rst` high clears every accumulator, carry and delay register. On the following cycle `acc_out` is 0 and `acc_vld` is 0.
- R2: `acc_out` is the sum of all accepted input words since reset, taken modulo 2^W. The carry out of the top slice is discarded.
- R3: An accepted input word is first included in `acc_out` after the PIPELINE-th advancing clock edge, counting the edge that samples it as the first. Before that edge, `acc_out` reflects only earlier words.
- R4: Carries cross every slice boundary, so the result matches a full-width addition even when a carry ripples through every slice. This includes a slice width of 1 bit.
- R5: In the every-clock mode (MODE = ADV_EVERY_CLK) every clock edge is an advancing edge. A word is accepted only when `en` is high, and a clock with `en` low contributes zero to the sum.
- R6: In the enable-gated mode (MODE = ADV_ON_EN) only edges with `en` high advance the pipeline, and each of them accepts `din`. On edges with `en` low, `acc_out` and `acc_vld` hold their values and `din` is ignored.
- R7: `acc_vld` rises with the output word that first includes an accepted input. In the every-clock mode, `acc_vld` after edge n equals `en` at edge n-PIPELINE+1. In the enable-gated mode, `acc_vld` is 1 once PIPELINE advancing edges have passed since reset.
- R8: A PIPELINE larger than NSTAGES changes only the latency, not the sequence of results.
- R9: With NSTAGES = 1 the block acts as a plain registered accumulator followed by PIPELINE-1 delay stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sample qualifier (every-clock mode) or advance enable (enable-gated mode) |
| din | input | W | Input word to add to the running sum |
| acc_out | output | W | Registered running sum |
| acc_vld | output | 1 | Marks output words that contain an accepted input |

## Verification
The assertions take for granted three things: `rst` is high at the first clock edge, `en` and `din` hold known, settled values at every rising edge, and `en` is a clean level rather than a pulse shorter than a clock. The stimulus keeps within these limits. It holds reset from time zero and changes every input only on the falling clock edge. `en` follows an LFSR pattern, so enabled and idle edges interleave irregularly. `din` mixes random words with directed words that force carries through every slice and make the sum wrap past 2^W.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

  // How the pipeline advances
  typedef enum logic [0:0] {
    ADV_EVERY_CLK = 1'b0,  // every register moves on each clock
    ADV_ON_EN     = 1'b1   // registers move only while en is high
  } adv_mode_e;

endpackage

// File: rtl/pacc_delay.sv
// Chain of DEPTH enabled registers with synchronous clear. DEPTH >= 1.
module pacc_delay #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 1
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(DEPTH); i++) stg[i] <= '0;
    end else if (adv) begin
      stg[0] <= d;
      for (int i = 1; i < int'(DEPTH); i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[DEPTH-1];

  // R1: the tap is clear after a reset edge
  assert_delay_clear_R1: assert property (@(posedge clk) rst |=> (q == '0));

  // R6: no advance means the tap holds
  assert_delay_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(q));

endmodule

// File: rtl/pacc_slice.sv
// One slice of the sum: SW-bit accumulator with a registered carry out.
module pacc_slice #(
  parameter int unsigned SW = 8
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          cin,
  input  logic [SW-1:0] din,
  output logic [SW-1:0] sum_o,
  output logic          carry_o
);

  logic [SW-1:0] sum_q;
  logic          carry_q;
  logic [SW:0]   add_w;

  always_comb begin
    add_w = {1'b0, sum_q} + {1'b0, din} + {{SW{1'b0}}, cin};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      carry_q <= 1'b0;
    end else if (adv) begin
      sum_q   <= add_w[SW-1:0];
      carry_q <= add_w[SW];
    end
  end

  assign sum_o   = sum_q;
  assign carry_o = carry_q;

  // R1: slice state clears on reset
  assert_slice_clear_R1: assert property (@(posedge clk)
    rst |=> (sum_q == '0 && !carry_q));

  // R6: without an advance the slice state is frozen
  assert_slice_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(sum_q) && $stable(carry_q)));

endmodule

// File: rtl/carry_split_acc.sv
module carry_split_acc
  import pacc_pkg::*;
#(
  parameter int unsigned W        = 32,
  parameter int unsigned NSTAGES  = 4,
  parameter int unsigned PIPELINE = 4,
  parameter adv_mode_e   MODE     = ADV_EVERY_CLK
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] acc_out,
  output logic         acc_vld
);

  localparam int unsigned SW    = W / NSTAGES;
  localparam bit          GATED = (MODE == ADV_ON_EN);

  generate
    if (NSTAGES == 0 || (W % NSTAGES) != 0 || PIPELINE < NSTAGES) begin : g_bad_cfg
      $error("carry_split_acc: W must divide by NSTAGES and PIPELINE >= NSTAGES");
    end
  endgenerate

  logic               adv;
  logic               inj_vld;
  logic [W-1:0]       inj_data;
  logic [NSTAGES-1:0] cin_w;

  always_comb begin
    adv      = GATED ? en : 1'b1;
    inj_vld  = GATED ? 1'b1 : en;
    inj_data = (GATED || en) ? din : '0;
  end

  assign cin_w[0] = 1'b0;

  generate
    for (genvar k = 0; k < int'(NSTAGES); k++) begin : g_slice
      localparam int unsigned TAIL = PIPELINE - 1 - k;
      logic [SW-1:0] skewed;
      logic [SW-1:0] sum_k;

      // input skew: slice k waits k steps for the carry from below
      if (k == 0) begin : g_noskew
        assign skewed = inj_data[SW-1:0];
      end else begin : g_skew
        pacc_delay #(.WIDTH(SW), .DEPTH(k)) u_skew (
          .clk(clk), .rst(rst), .adv(adv),
          .d(inj_data[k*SW +: SW]), .q(skewed)
        );
      end

      if (k == int'(NSTAGES) - 1) begin : g_top
        logic carry_unused;
        pacc_slice #(.SW(SW)) u_acc (
          .clk(clk), .rst(rst), .adv(adv), .cin(cin_w[k]),
          .din(skewed), .sum_o(sum_k), .carry_o(carry_unused)
        );
      end else begin : g_mid
        pacc_slice #(.SW(SW)) u_acc (
          .clk(clk), .rst(rst), .adv(adv), .cin(cin_w[k]),
          .din(skewed), .sum_o(sum_k), .carry_o(cin_w[k+1])
        );
      end

      // output deskew plus any surplus latency columns
      if (TAIL == 0) begin : g_notail
        assign acc_out[k*SW +: SW] = sum_k;
      end else begin : g_tail
        pacc_delay #(.WIDTH(SW), .DEPTH(TAIL)) u_tail (
          .clk(clk), .rst(rst), .adv(adv),
          .d(sum_k), .q(acc_out[k*SW +: SW])
        );
      end
    end
  endgenerate

  pacc_delay #(.WIDTH(1), .DEPTH(PIPELINE)) u_vld (
    .clk(clk), .rst(rst), .adv(adv), .d(inj_vld), .q(acc_vld)
  );

  // R1: outputs clear after a reset edge
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (acc_out == '0 && !acc_vld));

  generate
    if (GATED) begin : g_chk_gated
      // R6: an idle edge leaves the outputs untouched
      assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(acc_out) && $stable(acc_vld)));
      // R7: once valid, stays valid until reset
      assert_valid_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        acc_vld |=> acc_vld);
    end else begin : g_chk_clk
      // R5: a word that carried no sample adds nothing to the sum
      assert_idle_keeps_sum_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !acc_vld) |-> (acc_out == $past(acc_out)));
    end
  endgenerate

endmodule

// File: tb/sim_carry_split_acc.sv
module sim_acc_model #(
  parameter int unsigned W       = 8,
  parameter int unsigned P       = 1,
  parameter bit          EN_MODE = 1'b0
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] exp_sum,
  output logic         exp_vld
);
  logic [W-1:0] run;
  logic [W-1:0] hs [P];
  logic         hv [P];

  always @(posedge clk) begin : upd
    logic [W-1:0] inj;
    logic [W-1:0] nxt;
    if (rst) begin
      run <= '0;
      for (int i = 0; i < int'(P); i++) begin hs[i] <= '0; hv[i] <= 1'b0; end
    end else if (!EN_MODE || en) begin
      inj = (EN_MODE || en) ? din : '0;
      nxt = run + inj;
      run <= nxt;
      hs[0] <= nxt;
      hv[0] <= EN_MODE ? 1'b1 : en;
      for (int i = 1; i < int'(P); i++) begin hs[i] <= hs[i-1]; hv[i] <= hv[i-1]; end
    end
  end

  assign exp_sum = hs[P-1];
  assign exp_vld = hv[P-1];
endmodule

module sim_carry_split_acc;
  import pacc_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [31:0] din = '0;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;
  string tag     = "R1";
  logic [15:0] lf = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  // lanes: u0 W32/N4/P4 clk, u1 W32/N4/P7 en, u2 W24/N3/P5 clk,
  //        u3 W16/N1/P2 en, u4 W8/N8/P10 clk
  logic [31:0] s0, e0, s1, e1;
  logic [23:0] s2, e2;
  logic [15:0] s3, e3;
  logic [7:0]  s4, e4;
  logic v0, x0, v1, x1, v2, x2, v3, x3, v4, x4;

  carry_split_acc #(.W(32), .NSTAGES(4), .PIPELINE(4), .MODE(ADV_EVERY_CLK)) u0 (
    .clk(clk), .rst(rst), .en(en), .din(din), .acc_out(s0), .acc_vld(v0));
  carry_split_acc #(.W(32), .NSTAGES(4), .PIPELINE(7), .MODE(ADV_ON_EN)) u1 (
    .clk(clk), .rst(rst), .en(en), .din(din), .acc_out(s1), .acc_vld(v1));
  carry_split_acc #(.W(24), .NSTAGES(3), .PIPELINE(5), .MODE(ADV_EVERY_CLK)) u2 (
    .clk(clk), .rst(rst), .en(en), .din(din[23:0]), .acc_out(s2), .acc_vld(v2));
  carry_split_acc #(.W(16), .NSTAGES(1), .PIPELINE(2), .MODE(ADV_ON_EN)) u3 (
    .clk(clk), .rst(rst), .en(en), .din(din[15:0]), .acc_out(s3), .acc_vld(v3));
  carry_split_acc #(.W(8), .NSTAGES(8), .PIPELINE(10), .MODE(ADV_EVERY_CLK)) u4 (
    .clk(clk), .rst(rst), .en(en), .din(din[7:0]), .acc_out(s4), .acc_vld(v4));

  sim_acc_model #(.W(32), .P(4),  .EN_MODE(1'b0)) m0 (.clk(clk), .rst(rst), .en(en), .din(din),       .exp_sum(e0), .exp_vld(x0));
  sim_acc_model #(.W(32), .P(7),  .EN_MODE(1'b1)) m1 (.clk(clk), .rst(rst), .en(en), .din(din),       .exp_sum(e1), .exp_vld(x1));
  sim_acc_model #(.W(24), .P(5),  .EN_MODE(1'b0)) m2 (.clk(clk), .rst(rst), .en(en), .din(din[23:0]), .exp_sum(e2), .exp_vld(x2));
  sim_acc_model #(.W(16), .P(2),  .EN_MODE(1'b1)) m3 (.clk(clk), .rst(rst), .en(en), .din(din[15:0]), .exp_sum(e3), .exp_vld(x3));
  sim_acc_model #(.W(8),  .P(10), .EN_MODE(1'b0)) m4 (.clk(clk), .rst(rst), .en(en), .din(din[7:0]),  .exp_sum(e4), .exp_vld(x4));

  task automatic chk(input string req, input string lane,
                     input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, lane, got, exp);
    end
  endtask

  task automatic check_all();
    chk(tag,               "u0 sum", s0, e0);
    chk("R7",              "u0 vld", 32'(v0), 32'(x0));
    chk({"R8 ", tag},      "u1 sum", s1, e1);
    chk("R7",              "u1 vld", 32'(v1), 32'(x1));
    chk({"R8 ", tag},      "u2 sum", 32'(s2), 32'(e2));
    chk("R7",              "u2 vld", 32'(v2), 32'(x2));
    chk({"R9 ", tag},      "u3 sum", 32'(s3), 32'(e3));
    chk("R7",              "u3 vld", 32'(v3), 32'(x3));
    chk({"R4 ", tag},      "u4 sum", 32'(s4), 32'(e4));
    chk("R7",              "u4 vld", 32'(v4), 32'(x4));
  endtask

  task automatic step(input logic r, input logic e, input logic [31:0] d);
    @(negedge clk);
    if (!done) check_all();
    rst = r;
    en  = e;
    din = d;
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    int first0;
    int first2;
    logic [31:0] hold1;
    logic [15:0] hold3;
    logic hv1;
    logic hv3;
    void'($urandom(32'd4242));

    // R1: reset from time zero
    tag = "R1";
    repeat (3) step(1'b1, 1'b0, 32'd0);

    // R3: single word, then idle; find first edge showing it
    tag = "R3";
    step(1'b0, 1'b1, 32'd5);
    first0 = 0;
    first2 = 0;
    for (int i = 1; i <= 12; i++) begin
      step(1'b0, 1'b0, 32'd0);
      if (first0 == 0 && s0 != 0) first0 = i;
      if (first2 == 0 && s2 != 0) first2 = i;
    end
    chk("R3", "u0 first edge", 32'(first0), 32'd4);
    chk("R3", "u2 first edge", 32'(first2), 32'd5);
    chk("R5", "u0 idle sum", s0, 32'd5);

    // R4: carries rippling through every slice
    tag = "R4";
    step(1'b0, 1'b1, 32'h00FF00FF);
    step(1'b0, 1'b1, 32'h00000001);
    step(1'b0, 1'b1, 32'hFFFFFFFF);
    step(1'b0, 1'b1, 32'h00000001);
    step(1'b0, 1'b1, 32'h7FFFFFFF);
    step(1'b0, 1'b1, 32'h80000001);
    step(1'b0, 1'b1, 32'h0000FFFF);
    step(1'b0, 1'b1, 32'h00010001);
    for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 32'd0);

    // R2: repeated all-ones wraps the sum
    tag = "R2";
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 32'hFFFFFFFF);
    step(1'b0, 1'b1, 32'd1);
    for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 32'd0);

    // R5: irregular en in every-clock lanes
    tag = "R5";
    for (int i = 0; i < 300; i++) begin
      lf = lfsr_next(lf);
      step(1'b0, lf[0], $urandom);
    end

    // R6: enable-gated lanes freeze while en is low
    tag = "R6";
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, $urandom);
    step(1'b0, 1'b0, $urandom);
    hold1 = s1; hold3 = s3; hv1 = v1; hv3 = v3;
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, $urandom);
    chk("R6", "u1 held sum", s1, hold1);
    chk("R6", "u3 held sum", 32'(s3), 32'(hold3));
    chk("R6", "u1 held vld", 32'(v1), 32'(hv1));
    chk("R6", "u3 held vld", 32'(v3), 32'(hv3));

    // R1: reset in mid-run
    tag = "R1";
    step(1'b1, 1'b1, $urandom);
    step(1'b0, 1'b0, 32'd0);
    chk("R1", "u0 sum",  s0, 32'd0);
    chk("R1", "u1 sum",  s1, 32'd0);
    chk("R1", "u4 sum",  32'(s4), 32'd0);
    chk("R1", "u0 vld",  32'(v0), 32'd0);
    chk("R1", "u1 vld",  32'(v1), 32'd0);

    // R8: long random run with mixed en density
    tag = "R8";
    for (int i = 0; i < 1500; i++) begin
      lf = lfsr_next(lf);
      step(1'b0, (i < 750) ? (lf[0] | lf[3]) : (lf[0] & lf[5]), $urandom);
    end
    step(1'b0, 1'b0, 32'd0);

    done = 1'b1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R3 watchdog: got timeout expected completion");
    done = 1'b1;
    report();
  end

endmodule